// File: doc/BRIEF.md
# Eight-Input Vectored Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines into one interrupt output for a processor. It resolves them in fixed priority, with line 0 the most urgent, and tracks which lines have a handler running. A new request reaches the processor only when it outranks every handler already in service, so handlers nest strictly by priority. The processor answers with a one-cycle acknowledge. One cycle later the block returns an 8-bit vector: the line number ORed into a programmable base whose low three bits are zero.

Software reaches a small register port. It holds a per-line mask, the vector base and a global enable, and it can read back the request and in-service state. A write to the in-service address is a non-specific end-of-interrupt: it retires the most urgent handler in service. A separate non-maskable input is edge-detected and raises its own one-cycle pulse output. Neither the mask nor the global enable affects that input.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_o and vec_vld_o are low, the mask reads 0xFF (all lines inhibited), the global enable reads 0, the vector base reads 0x00, and the request and in-service registers read 0x00.
- R2: Each request line passes through a two-flop synchronizer and is then sampled as a level into the request register. The register reads at address 4. A line set before rising edge k shows there after edge k+2, and not after edge k+1.
- R3: The mask register (address 0, read/write) holds bit i = 1 to keep line i from raising int_o.
- R4: Bit 0 of the control register (address 2, read/write) is the global enable. While it is 0, int_o stays low whatever the requests are.
- R5: Priority is fixed, with lower index more urgent. int_o is high only when the enable is 1, some unmasked request is pending, and the lowest pending unmasked index is below the lowest set in-service index (any index qualifies when nothing is in service).
- R6: When inta_i is high for a cycle in which int_o is high, vec_vld_o is high in the next cycle with vec_o = base | winning index. In that same next cycle the winning in-service bit is set and its request bit reads 0.
- R7: The vector base register (address 1) stores bits 7:3 of a write. Bits 2:0 always read 0.
- R8: An acknowledge while int_o is low returns vec_o = base | 7 with vec_vld_o high and changes neither the request nor the in-service register.
- R9: Any write to address 3 clears the lowest-index set bit of the in-service register, which reads at address 3. When the in-service register is empty, the write changes nothing.
- R10: A rising edge on nmi_i gives exactly one one-cycle nmi_o pulse. If the edge lands before rising edge k, the pulse is high after edge k+1. The mask register and the global enable have no effect on it.
- R11: An acknowledge and an end-of-interrupt write in the same cycle both take effect. The handler retired is the one in service before that cycle, and the acknowledged line enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Level-sensitive request lines, bit 0 most urgent |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 mask, 1 base, 2 control, 3 in-service/EOI, 4 request |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| inta_i | input | 1 | Acknowledge from the processor, one cycle |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_vld_o | output | 1 | vec_o valid, one cycle after inta_i |
| nmi_o | output | 1 | One-cycle pulse per non-maskable edge |

## Verification
The bound checker watches four behaviours on every cycle:
- int_o never rises unless a pending unmasked request sits below the lowest in-service bit.
- Every acknowledge produces a valid vector on the next cycle.
- A granted acknowledge moves exactly one bit from the request register into service.
- An end-of-interrupt retires exactly one handler, and nmi_o never lasts two cycles.

The bench scenarios cover what a single-cycle property cannot:
- the exact synchronizer latency;
- the numeric vector values for a given base;
- nesting across several acknowledges;
- the spurious-acknowledge vector;
- the same-cycle acknowledge with end-of-interrupt;
- the non-maskable pulse with every line masked and the enable off.

A bench model of mask, enable and in-service state checks int_o under random request and mask patterns.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam logic [2:0] ADR_MASK = 3'd0;
   localparam logic [2:0] ADR_BASE = 3'd1;
   localparam logic [2:0] ADR_CTRL = 3'd2;
   localparam logic [2:0] ADR_ISRV = 3'd3;   // read: in-service, write: EOI
   localparam logic [2:0] ADR_REQ  = 3'd4;
endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/prio_irq_enc.sv
module prio_irq_enc #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     v_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (v_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_irq_edge.sv
module prio_irq_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);
   logic lvl, lvl_d;

   prio_irq_sync #(.W(1), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(d_i), .q_o(lvl)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;

   assign rise_o = lvl & ~lvl_d;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_SRC     = 8,
   parameter int VEC_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_i,
   input  logic               nmi_i,
   input  logic               reg_wr_i,
   input  logic [2:0]         reg_addr_i,
   input  logic [VEC_W-1:0]   reg_wdata_i,
   output logic [VEC_W-1:0]   reg_rdata_o,
   input  logic               inta_i,
   output logic               int_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic               vec_vld_o,
   output logic               nmi_o
);
   import prio_irq_pkg::*;

   localparam int IDX_W = $clog2(NUM_SRC);

   generate
      if (NUM_SRC != (1 << IDX_W) || NUM_SRC < 2)
         $error("NUM_SRC must be a power of two of at least 2");
      if (VEC_W <= IDX_W || NUM_SRC > VEC_W)
         $error("VEC_W must exceed the index width and cover NUM_SRC");
      if (SYNC_STAGES < 2)
         $error("SYNC_STAGES must be at least 2");
   endgenerate

   logic [NUM_SRC-1:0] req_sync, irr_q, isr_q, mask_q, pend;
   logic [NUM_SRC-1:0] ack_sel, eoi_sel;
   logic [VEC_W-1:0]   base_q, vec_q;
   logic               gen_q, vld_q;
   logic               p_any, s_any, ack, eoi_cmd;
   logic [IDX_W-1:0]   p_idx, s_idx;

   prio_irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d_i(irq_i), .q_o(req_sync)
   );

   prio_irq_edge #(.STAGES(SYNC_STAGES)) u_nmi (
      .clk(clk), .rst_n(rst_n), .d_i(nmi_i), .rise_o(nmi_o)
   );

   assign pend = irr_q & ~mask_q;

   prio_irq_enc #(.N(NUM_SRC)) u_pend_enc (.v_i(pend),  .any_o(p_any), .idx_o(p_idx));
   prio_irq_enc #(.N(NUM_SRC)) u_serv_enc (.v_i(isr_q), .any_o(s_any), .idx_o(s_idx));

   assign int_o   = gen_q & p_any & (~s_any | (p_idx < s_idx));
   assign ack     = inta_i & int_o;
   assign eoi_cmd = reg_wr_i & (reg_addr_i == ADR_ISRV);
   assign ack_sel = ack ? (NUM_SRC'(1) << p_idx) : '0;
   assign eoi_sel = (eoi_cmd & s_any) ? (NUM_SRC'(1) << s_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
      end else begin
         irr_q <= req_sync & ~ack_sel;
         isr_q <= (isr_q & ~eoi_sel) | ack_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         base_q <= '0;
         gen_q  <= 1'b0;
      end else if (reg_wr_i) begin
         case (reg_addr_i)
            ADR_MASK: mask_q <= reg_wdata_i[NUM_SRC-1:0];
            ADR_BASE: base_q <= {reg_wdata_i[VEC_W-1:IDX_W], {IDX_W{1'b0}}};
            ADR_CTRL: gen_q  <= reg_wdata_i[0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= inta_i;
         if (inta_i)
            vec_q <= base_q | (ack ? VEC_W'(p_idx) : VEC_W'(NUM_SRC - 1));
      end
   end

   assign vec_o     = vec_q;
   assign vec_vld_o = vld_q;

   always_comb begin
      case (reg_addr_i)
         ADR_MASK: reg_rdata_o = VEC_W'(mask_q);
         ADR_BASE: reg_rdata_o = base_q;
         ADR_CTRL: reg_rdata_o = VEC_W'(gen_q);
         ADR_ISRV: reg_rdata_o = VEC_W'(isr_q);
         ADR_REQ:  reg_rdata_o = VEC_W'(irr_q);
         default:  reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int NUM_SRC = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               int_o,
   input logic               inta_i,
   input logic               vec_vld_o,
   input logic               nmi_o,
   input logic               eoi_cmd,
   input logic [NUM_SRC-1:0] irr_q,
   input logic [NUM_SRC-1:0] isr_q,
   input logic [NUM_SRC-1:0] mask_q
);
   logic [NUM_SRC-1:0] serv_low, below_serv;
   assign serv_low   = isr_q & (~isr_q + NUM_SRC'(1));
   assign below_serv = serv_low - NUM_SRC'(1);

   AST_INT_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> ((irr_q & ~mask_q & below_serv) != '0));                          // R5
   AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      inta_i |=> vec_vld_o);                                                        // R6
   AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_i && int_o && !eoi_cmd) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R6
   AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_i && int_o) |=> ((irr_q & isr_q & ~$past(isr_q)) == '0));               // R6
   AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_cmd && !(inta_i && int_o) && isr_q != '0) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R9
   AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |=> !nmi_o);                                                            // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
   .clk(clk), .rst_n(rst_n), .int_o(int_o), .inta_i(inta_i),
   .vec_vld_o(vec_vld_o), .nmi_o(nmi_o), .eoi_cmd(eoi_cmd),
   .irr_q(irr_q), .isr_q(isr_q), .mask_q(mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_i = '0;
   logic       nmi_i = 1'b0;
   logic       reg_wr_i = 1'b0;
   logic [2:0] reg_addr_i = '0;
   logic [7:0] reg_wdata_i = '0;
   logic [7:0] reg_rdata_o;
   logic       inta_i = 1'b0;
   logic       int_o, vec_vld_o, nmi_o;
   logic [7:0] vec_o;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 0;
   logic [7:0] mask_m, base_m, isr_m;
   logic       gen_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .inta_i(inta_i), .int_o(int_o),
      .vec_o(vec_o), .vec_vld_o(vec_vld_o), .nmi_o(nmi_o)
   );

   function automatic int low_idx(logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic logic exp_int(logic [7:0] lvl);
      return gen_m && (low_idx(lvl & ~mask_m) < low_idx(isr_m));
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      @(negedge clk);
      reg_wr_i = 1'b0;
      if (a == 3'd3 && isr_m != 0) isr_m[low_idx(isr_m)] = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      reg_addr_i = a; #1; d = reg_rdata_o;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // acknowledge and check vector, in-service and cleared request bit
   task automatic do_ack(string req);
      logic [7:0] r;
      int idx;
      logic e;
      e = exp_int(irq_i);
      idx = e ? low_idx(irq_i & ~mask_m) : 7;
      inta_i = 1'b1;
      @(negedge clk);
      inta_i = 1'b0;
      if (e) isr_m[idx] = 1'b1;
      check(vec_vld_o === 1'b1, req, vec_vld_o, 1);
      check(vec_o === (base_m | 8'(idx)), req, vec_o, base_m | 8'(idx));
      rd(3'd3, r);
      check(r === isr_m, req, r, isr_m);
      rd(3'd4, r);
      check(r === (e ? (irq_i & ~(8'd1 << idx)) : irq_i), req, r, irq_i);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [7:0] r;
      int np;
      void'($urandom(32'h5eed_0017));
      mask_m = 8'hFF; base_m = 8'h00; isr_m = 8'h00; gen_m = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(int_o === 1'b0 && vec_vld_o === 1'b0, "R1 outputs", {int_o, vec_vld_o}, 0);
      rd(3'd0, r); check(r === 8'hFF, "R1 mask", r, 8'hFF);
      rd(3'd1, r); check(r === 8'h00, "R1 base", r, 0);
      rd(3'd2, r); check(r === 8'h00, "R1 ctrl", r, 0);
      rd(3'd3, r); check(r === 8'h00, "R1 isr", r, 0);
      rd(3'd4, r); check(r === 8'h00, "R1 irr", r, 0);

      // R2 synchronizer latency
      irq_i = 8'h24;
      @(negedge clk); @(negedge clk);
      rd(3'd4, r); check(r === 8'h00, "R2 not yet", r, 0);
      @(negedge clk);
      rd(3'd4, r); check(r === 8'h24, "R2 latched", r, 8'h24);

      // R3 / R4 mask and global enable
      wr(3'd2, 8'h01); gen_m = 1;
      check(int_o === 1'b0, "R3 all masked", int_o, 0);
      wr(3'd2, 8'h00); gen_m = 0;
      wr(3'd0, 8'h04); mask_m = 8'h04;
      check(int_o === 1'b0, "R4 enable off", int_o, 0);
      wr(3'd2, 8'h01); gen_m = 1;
      check(int_o === 1'b1, "R3 line5 unmasked", int_o, 1);
      wr(3'd0, 8'h00); mask_m = 8'h00;

      // R7 base
      wr(3'd1, 8'hAB); base_m = 8'hA8;
      rd(3'd1, r); check(r === 8'hA8, "R7 base low bits", r, 8'hA8);

      // R6 / R5 nesting
      do_ack("R6 ack line2");
      check(vec_o === 8'hAA, "R6 vector AA", vec_o, 8'hAA);
      @(negedge clk);
      check(vec_vld_o === 1'b0, "R6 valid one cycle", vec_vld_o, 0);
      rd(3'd4, r); check(r === 8'h24, "R2 level relatch", r, 8'h24);
      check(int_o === 1'b0, "R5 same level blocked", int_o, 1'b0);
      irq_i = 8'h25; settle();
      check(int_o === 1'b1, "R5 higher preempts", int_o, 1);
      do_ack("R6 ack line0");
      settle();
      check(int_o === 1'b0, "R5 line0 in service", int_o, 0);

      // R8 spurious
      do_ack("R8 spurious");
      check(vec_o === 8'hAF, "R8 vector", vec_o, 8'hAF);

      // R9 / R11
      wr(3'd3, 8'h00);
      rd(3'd3, r); check(r === 8'h04, "R9 eoi clears lowest", r, 8'h04);
      check(int_o === 1'b1, "R5 after eoi", int_o, 1);
      inta_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 3'd3;
      @(negedge clk);
      inta_i = 1'b0; reg_wr_i = 1'b0;
      isr_m = 8'h01;
      check(vec_o === 8'hA8, "R11 vector", vec_o, 8'hA8);
      rd(3'd3, r); check(r === 8'h01, "R11 isr", r, 8'h01);
      wr(3'd3, 8'h00); wr(3'd3, 8'h00);
      rd(3'd3, r); check(r === 8'h00, "R9 empty eoi", r, 0);

      // R10 NMI with everything masked and disabled
      irq_i = 8'h00;
      wr(3'd0, 8'hFF); mask_m = 8'hFF;
      wr(3'd2, 8'h00); gen_m = 0;
      nmi_i = 1'b1;
      @(negedge clk); check(nmi_o === 1'b0, "R10 early", nmi_o, 0);
      @(negedge clk); check(nmi_o === 1'b1, "R10 pulse", nmi_o, 1);
      np = 0;
      repeat (6) begin @(negedge clk); if (nmi_o) np++; end
      check(np == 0, "R10 single pulse", np, 0);
      nmi_i = 1'b0; settle();

      // random phase
      wr(3'd2, 8'h01); gen_m = 1;
      for (int it = 0; it < 300; it++) begin
         irq_i = 8'($urandom);
         if ($urandom_range(3) == 0) begin
            logic [7:0] m;
            m = 8'($urandom) & 8'($urandom);
            wr(3'd0, m); mask_m = m;
         end
         if ($urandom_range(9) == 0) begin
            logic g;
            g = 1'($urandom);
            wr(3'd2, {7'd0, g}); gen_m = g;
         end
         settle();
         check(int_o === exp_int(irq_i), "R5 random int", int_o, exp_int(irq_i));
         if ($urandom_range(1) == 0) do_ack("R6 random ack");
         if ($urandom_range(2) != 0) begin
            wr(3'd3, 8'h00);
            rd(3'd3, r); check(r === isr_m, "R9 random eoi", r, isr_m);
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule